// File: doc/BRIEF.md
# Lock Acquire/Release Sequencer

This block runs four privileged lock operations as a short microsequence over a word-wide memory port. The four operations are acquiring and releasing a global resource lock, and acquiring and releasing a local lock that belongs to one address space. For each operation the block reads its operand words and the held-lock indicator word. It then reads the lockword and decides whether the operation may go ahead. If it may, the block asks memory for one atomic update: a conditional word swap for an acquire, or a conditional doubleword clear for a release. It then rewrites the held-lock indicator and reports success by writing zero into register 13.

If the test fails, or the atomic update is refused, the block does not retry. It reports register 12 with the return address. It reads a handler word from a fixed offset below the lock-interface table and reports that word as register 13. It also reports a program-counter redirect taken from the handler word. The addressing-mode bit is never output, so it stays unchanged.

The surrounding pipeline supplies the operand addresses and the global lockword pointer. It pulses `start_i` and waits for the single-cycle `done_o`. The register and PC outputs are valid only in that cycle.

Top module: `lock_seq`

## Requirements
- R1: `op_i` selects the operation: 0 acquires the global lock, 1 acquires the local lock, 2 releases the global lock, 3 releases the local lock. An acquire succeeds only when the lockword reads zero. It then issues a swap command (`mem_cmd_o`=2) at the lockword address. On success `r13_we_o` is high with `r13_o`=0, and `pc_we_o` and `r12_we_o` stay low.
- R2: For the local acquire, the lockword sits at the address word read from the first operand plus LOCAL_OFF (default 0x80). The value stored is the word at second operand minus 4. On success bit 0 (local) of the indicator word at the second operand is set.
- R3: The global acquire uses the lockword addressed by `lock_ptr_i` and stores the first-operand word. It also requires indicator bit 0 set and bit 1 (global) clear. On success it sets indicator bit 1.
- R4: A release requires the word after the lockword to be zero. It issues a clear-doubleword command (`mem_cmd_o`=3) that carries the lockword read as its compare value. The global release also requires the lockword to equal the first-operand word and indicator bit 1 set. On success it clears bit 1. The local release requires bit 0 set and bit 1 clear. On success it clears bit 0.
- R5: On failure `r12_o` is `next_ia_i` with bit 31 cleared. `r13_o` is the word at the lock-interface-table base minus 8, 16, 4 or 12, for operations 0 to 3 in that order. The table base is the word that follows the second operand.
- R6: On failure `pc_we_o` is high and `pc_o` is the handler word masked to the current addressing width.
- R7: With `amode_i`=0, every operand address and every fetched address word is truncated to 24 bits. With `amode_i`=1 it is truncated to 31 bits.
- R8: A first or second operand address that is not word aligned, or a lockword address that is not doubleword aligned, ends the operation with `spec_o` high. No write command is issued and no register or PC write happens.
- R9: An acquire pulses `sync_o` once before the lockword read, and once more after a successful update. A release never pulses `sync_o`.
- R10: A swap or clear that memory refuses (`mem_ok_i`=0) takes the failure path of R5 and R6, with no retry.
- R11: With `fast_i` high at start, the operation finishes with no memory request, no register or PC write, and no `spec_o`.
- R12: `done_o` is high for exactly one cycle per operation. A memory request holds its command and address until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| op_i | input | 2 | Operation select |
| fast_i | input | 1 | Simplified-path mode |
| amode_i | input | 1 | Addressing mode: 1 = 31-bit, 0 = 24-bit |
| op1_addr_i | input | 32 | First-operand address |
| op2_addr_i | input | 32 | Second-operand address |
| lock_ptr_i | input | 32 | Global lockword address |
| next_ia_i | input | 32 | Updated instruction address |
| mem_req_o | output | 1 | Memory request |
| mem_cmd_o | output | 2 | 0 read, 1 write, 2 swap-if-zero, 3 clear doubleword |
| mem_addr_o | output | 32 | Request address |
| mem_wdata_o | output | 32 | Write, swap or compare data |
| mem_ack_i | input | 1 | Request acknowledge |
| mem_ok_i | input | 1 | Atomic update took place |
| mem_rdata_i | input | 32 | Read data |
| sync_o | output | 1 | Serialization pulse |
| done_o | output | 1 | Operation finished |
| spec_o | output | 1 | Specification exception |
| r12_we_o | output | 1 | Register 12 write |
| r12_o | output | 32 | Register 12 value |
| r13_we_o | output | 1 | Register 13 write |
| r13_o | output | 32 | Register 13 value |
| pc_we_o | output | 1 | PC redirect |
| pc_o | output | 32 | Redirect address |

## Verification
The assertions assume that memory raises `mem_ack_i` only while a request is pending. They also assume that `amode_i` stays constant from start to done, because the address-width checks compare request addresses against the live mode pin. The bench holds the mode and every operand input steady for the whole operation. Its memory model acknowledges one cycle after it sees a request, so both assumptions hold. To force a refused swap, the bench sets a flag that makes the model write into the lockword just before it performs the swap.

// File: rtl/lock_seq_pkg.sv
package lock_seq_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {OP_GACQ = 2'd0, OP_LACQ = 2'd1, OP_GREL = 2'd2, OP_LREL = 2'd3} op_e;
  typedef enum logic [1:0] {CMD_READ = 2'd0, CMD_WRITE = 2'd1, CMD_SWAP = 2'd2, CMD_CLRD = 2'd3} cmd_e;
  typedef enum logic [3:0] {
    S_IDLE, S_RD1, S_RD2, S_RDLIT, S_RDVAL, S_SYN1, S_RDLK0, S_RDLK1,
    S_EVAL, S_SWAP, S_CLRD, S_WRHLI, S_SYN2, S_RDHND, S_DONE
  } st_e;

  function automatic logic [DW-1:0] addr_mask(input logic [DW-1:0] a, input logic amode);
    return amode ? {1'b0, a[DW-2:0]} : {8'h00, a[DW-9:0]};
  endfunction

  function automatic logic is_acq(input op_e op);
    return (op == OP_GACQ) || (op == OP_LACQ);
  endfunction
endpackage

// File: rtl/lock_seq_eval.sv
module lock_seq_eval
  import lock_seq_pkg::*;
#(
  parameter int unsigned LOCAL_BIT  = 0,
  parameter int unsigned GLOBAL_BIT = 1
) (
  input  op_e           op_i,
  input  logic [DW-1:0] hli_i,
  input  logic [DW-1:0] op1w_i,
  input  logic [DW-1:0] lk0_i,
  input  logic [DW-1:0] lk1_i,
  output logic          pass_o,
  output logic [DW-1:0] hli_new_o,
  output logic [4:0]    lit_off_o
);
  logic has_l, has_g;
  assign has_l = hli_i[LOCAL_BIT];
  assign has_g = hli_i[GLOBAL_BIT];

  always_comb begin
    hli_new_o = hli_i;
    unique case (op_i)
      OP_GACQ: begin
        pass_o = has_l && !has_g && (lk0_i == '0);
        hli_new_o[GLOBAL_BIT] = 1'b1;
        lit_off_o = 5'd8;
      end
      OP_LACQ: begin
        pass_o = (lk0_i == '0);
        hli_new_o[LOCAL_BIT] = 1'b1;
        lit_off_o = 5'd16;
      end
      OP_GREL: begin
        pass_o = (lk0_i == op1w_i) && has_g && (lk1_i == '0);
        hli_new_o[GLOBAL_BIT] = 1'b0;
        lit_off_o = 5'd4;
      end
      default: begin
        pass_o = has_l && !has_g && (lk1_i == '0);
        hli_new_o[LOCAL_BIT] = 1'b0;
        lit_off_o = 5'd12;
      end
    endcase
  end
endmodule

// File: rtl/lock_seq_agen.sv
module lock_seq_agen
  import lock_seq_pkg::*;
#(
  parameter int unsigned LOCAL_OFF = 32'h80
) (
  input  logic          amode_i,
  input  op_e           op_i,
  input  logic [DW-1:0] op1_addr_i,
  input  logic [DW-1:0] op2_addr_i,
  input  logic [DW-1:0] op1_word_i,
  input  logic [DW-1:0] lock_ptr_i,
  input  logic [DW-1:0] lit_i,
  input  logic [4:0]    lit_off_i,
  output logic [DW-1:0] a_op1_o,
  output logic [DW-1:0] a_op2_o,
  output logic [DW-1:0] a_lit_o,
  output logic [DW-1:0] a_val_o,
  output logic [DW-1:0] a_lock_o,
  output logic [DW-1:0] a_lock1_o,
  output logic [DW-1:0] a_hnd_o,
  output logic          lock_ok_o
);
  logic [DW-1:0] ascb;
  assign ascb     = addr_mask(op1_word_i, amode_i);
  assign a_op1_o  = addr_mask(op1_addr_i, amode_i);
  assign a_op2_o  = addr_mask(op2_addr_i, amode_i);
  assign a_lit_o  = addr_mask(a_op2_o + 32'd4, amode_i);
  assign a_val_o  = addr_mask(a_op2_o - 32'd4, amode_i);
  assign a_lock_o = (op_i == OP_GACQ || op_i == OP_GREL) ? addr_mask(lock_ptr_i, amode_i)
                                                         : addr_mask(ascb + DW'(LOCAL_OFF), amode_i);
  assign a_lock1_o = addr_mask(a_lock_o + 32'd4, amode_i);
  assign a_hnd_o   = addr_mask(addr_mask(lit_i, amode_i) - {27'd0, lit_off_i}, amode_i);
  assign lock_ok_o = (a_lock_o[2:0] == 3'b000);
endmodule

// File: rtl/lock_seq.sv
module lock_seq
  import lock_seq_pkg::*;
#(
  parameter int unsigned LOCAL_OFF  = 32'h80,
  parameter int unsigned LOCAL_BIT  = 0,
  parameter int unsigned GLOBAL_BIT = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  op_i,
  input  logic        fast_i,
  input  logic        amode_i,
  input  logic [31:0] op1_addr_i,
  input  logic [31:0] op2_addr_i,
  input  logic [31:0] lock_ptr_i,
  input  logic [31:0] next_ia_i,
  output logic        mem_req_o,
  output logic [1:0]  mem_cmd_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic        mem_ok_i,
  input  logic [31:0] mem_rdata_i,
  output logic        sync_o,
  output logic        done_o,
  output logic        spec_o,
  output logic        r12_we_o,
  output logic [31:0] r12_o,
  output logic        r13_we_o,
  output logic [31:0] r13_o,
  output logic        pc_we_o,
  output logic [31:0] pc_o
);
  st_e           st_q;
  op_e           op_q;
  logic          amode_q, spec_q, fail_q, succ_q;
  logic [DW-1:0] op1a_q, op2a_q, lkp_q, op1w_q, hli_q, lit_q, val_q, lk0_q, lk1_q, r13_q;
  logic [DW-2:0] nia_q;

  logic [DW-1:0] a_op1, a_op2, a_lit, a_val, a_lock, a_lock1, a_hnd, hli_new;
  logic          lock_ok, pass;
  logic [4:0]    lit_off;
  st_e           lock_nxt;

  lock_seq_eval #(.LOCAL_BIT(LOCAL_BIT), .GLOBAL_BIT(GLOBAL_BIT)) u_eval (
    .op_i(op_q), .hli_i(hli_q), .op1w_i(op1w_q), .lk0_i(lk0_q), .lk1_i(lk1_q),
    .pass_o(pass), .hli_new_o(hli_new), .lit_off_o(lit_off)
  );

  lock_seq_agen #(.LOCAL_OFF(LOCAL_OFF)) u_agen (
    .amode_i(amode_q), .op_i(op_q), .op1_addr_i(op1a_q), .op2_addr_i(op2a_q),
    .op1_word_i(op1w_q), .lock_ptr_i(lkp_q), .lit_i(lit_q), .lit_off_i(lit_off),
    .a_op1_o(a_op1), .a_op2_o(a_op2), .a_lit_o(a_lit), .a_val_o(a_val),
    .a_lock_o(a_lock), .a_lock1_o(a_lock1), .a_hnd_o(a_hnd), .lock_ok_o(lock_ok)
  );

  // after setup reads: misaligned lock ends, acquire serializes first
  assign lock_nxt = !lock_ok ? S_DONE : (is_acq(op_q) ? S_SYN1 : S_RDLK0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; op_q <= OP_GACQ; amode_q <= 1'b0;
      spec_q <= 1'b0; fail_q <= 1'b0; succ_q <= 1'b0;
      op1a_q <= '0; op2a_q <= '0; lkp_q <= '0; nia_q <= '0;
      op1w_q <= '0; hli_q <= '0; lit_q <= '0; val_q <= '0;
      lk0_q <= '0; lk1_q <= '0; r13_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          op_q <= op_e'(op_i); amode_q <= amode_i;
          op1a_q <= op1_addr_i; op2a_q <= op2_addr_i; lkp_q <= lock_ptr_i;
          nia_q <= next_ia_i[DW-2:0];
          spec_q <= 1'b0; fail_q <= 1'b0; succ_q <= 1'b0;
          lk1_q <= '0;
          if (fast_i) st_q <= S_DONE;
          else if (op1_addr_i[1:0] != 2'b00 || op2_addr_i[1:0] != 2'b00) begin
            spec_q <= 1'b1; st_q <= S_DONE;
          end else st_q <= S_RD1;
        end
        S_RD1: if (mem_ack_i) begin op1w_q <= mem_rdata_i; st_q <= S_RD2; end
        S_RD2: if (mem_ack_i) begin hli_q <= mem_rdata_i; st_q <= S_RDLIT; end
        S_RDLIT: if (mem_ack_i) begin
          lit_q <= mem_rdata_i;
          if (op_q == OP_LACQ) st_q <= S_RDVAL;
          else begin st_q <= lock_nxt; spec_q <= !lock_ok; end
        end
        S_RDVAL: if (mem_ack_i) begin
          val_q <= mem_rdata_i; st_q <= lock_nxt; spec_q <= !lock_ok;
        end
        S_SYN1: st_q <= S_RDLK0;
        S_RDLK0: if (mem_ack_i) begin
          lk0_q <= mem_rdata_i;
          st_q <= is_acq(op_q) ? S_EVAL : S_RDLK1;
        end
        S_RDLK1: if (mem_ack_i) begin lk1_q <= mem_rdata_i; st_q <= S_EVAL; end
        S_EVAL: st_q <= !pass ? S_RDHND : (is_acq(op_q) ? S_SWAP : S_CLRD);
        S_SWAP, S_CLRD: if (mem_ack_i) st_q <= mem_ok_i ? S_WRHLI : S_RDHND;
        S_WRHLI: if (mem_ack_i) begin
          succ_q <= 1'b1;
          st_q <= is_acq(op_q) ? S_SYN2 : S_DONE;
        end
        S_SYN2: st_q <= S_DONE;
        S_RDHND: if (mem_ack_i) begin
          r13_q <= mem_rdata_i; fail_q <= 1'b1; st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b1;
    mem_cmd_o   = CMD_READ;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      S_RD1:   mem_addr_o = a_op1;
      S_RD2:   mem_addr_o = a_op2;
      S_RDLIT: mem_addr_o = a_lit;
      S_RDVAL: mem_addr_o = a_val;
      S_RDLK0: mem_addr_o = a_lock;
      S_RDLK1: mem_addr_o = a_lock1;
      S_RDHND: mem_addr_o = a_hnd;
      S_SWAP: begin
        mem_cmd_o = CMD_SWAP; mem_addr_o = a_lock;
        mem_wdata_o = (op_q == OP_GACQ) ? op1w_q : val_q;
      end
      S_CLRD: begin
        mem_cmd_o = CMD_CLRD; mem_addr_o = a_lock; mem_wdata_o = lk0_q;
      end
      S_WRHLI: begin
        mem_cmd_o = CMD_WRITE; mem_addr_o = a_op2; mem_wdata_o = hli_new;
      end
      default: mem_req_o = 1'b0;
    endcase
  end

  assign sync_o   = (st_q == S_SYN1) || (st_q == S_SYN2);
  assign done_o   = (st_q == S_DONE);
  assign spec_o   = done_o && spec_q;
  assign r13_we_o = done_o && (succ_q || fail_q);
  assign r13_o    = fail_q ? r13_q : '0;
  assign r12_we_o = done_o && fail_q;
  assign r12_o    = {1'b0, nia_q};
  assign pc_we_o  = done_o && fail_q;
  assign pc_o     = addr_mask(r13_q, amode_q);
endmodule

// File: rtl/lock_seq_chk.sv
module lock_seq_chk
  import lock_seq_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        amode_i,
  input logic        mem_req_o,
  input logic [1:0]  mem_cmd_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_ack_i,
  input logic        sync_o,
  input logic        done_o,
  input logic        spec_o,
  input logic        r12_we_o,
  input logic [31:0] r12_o,
  input logic        r13_we_o,
  input logic [31:0] r13_o,
  input logic        pc_we_o
);
  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_cmd_o));
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_spec_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_o |-> done_o && !r12_we_o && !r13_we_o && !pc_we_o);
  p_fail_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> r12_we_o && r13_we_o && !r12_o[31]);
  p_succ_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r13_we_o && !pc_we_o |-> r13_o == 32'd0);
  p_dw_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && (mem_cmd_o == CMD_SWAP || mem_cmd_o == CMD_CLRD) |-> mem_addr_o[2:0] == 3'b000);
  p_addr24_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !amode_i |-> mem_addr_o[31:24] == 8'h00);
  p_addr31_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !mem_addr_o[31]);
  p_sync_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> !mem_req_o && !done_o);
  p_out_in_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r12_we_o || r13_we_o || pc_we_o || spec_o) |-> done_o);
endmodule

bind lock_seq lock_seq_chk u_chk (.*);

// File: tb/sim_lock_seq.sv
module sim_lock_seq;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, fast_i = 0, amode_i = 1;
  logic [1:0] op_i = 0;
  logic [31:0] op1_addr_i = 0, op2_addr_i = 0, lock_ptr_i = 0, next_ia_i = 0;
  logic mem_req_o, mem_ack_i = 0, mem_ok_i = 0;
  logic [1:0] mem_cmd_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = 0;
  logic sync_o, done_o, spec_o, r12_we_o, r13_we_o, pc_we_o;
  logic [31:0] r12_o, r13_o, pc_o;

  always #4 clk = ~clk;

  lock_seq u0 (.clk_i(clk), .rst_ni, .start_i, .op_i, .fast_i, .amode_i, .op1_addr_i, .op2_addr_i,
    .lock_ptr_i, .next_ia_i, .mem_req_o, .mem_cmd_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i,
    .mem_ok_i, .mem_rdata_i, .sync_o, .done_o, .spec_o, .r12_we_o, .r12_o, .r13_we_o, .r13_o,
    .pc_we_o, .pc_o);

  int n_cmp = 0, n_bad = 0, n_done = 0;
  int wr_cnt = 0, req_cnt = 0, syn_cnt = 0;
  bit steal = 0;
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction
  function automatic logic [31:0] msk(input logic [31:0] a, input bit am);
    return am ? (a & 32'h7FFF_FFFF) : (a & 32'h00FF_FFFF);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model: acknowledges one cycle after seeing a request
  always @(negedge clk) begin
    if (mem_ack_i) mem_ack_i = 0;
    else if (mem_req_o) begin
      mem_ack_i = 1; mem_ok_i = 0; req_cnt++;
      case (mem_cmd_o)
        2'd0: mem_rdata_i = mrd(mem_addr_o);
        2'd1: begin mem[mem_addr_o] = mem_wdata_o; wr_cnt++; end
        2'd2: begin
          wr_cnt++;
          if (steal) mem[mem_addr_o] = 32'hDEAD_0001;
          if (mrd(mem_addr_o) == 0) begin mem[mem_addr_o] = mem_wdata_o; mem_ok_i = 1; end
        end
        default: begin
          wr_cnt++;
          if (mrd(mem_addr_o) == mem_wdata_o && mrd(mem_addr_o + 4) == 0) begin
            mem[mem_addr_o] = 0; mem[mem_addr_o + 4] = 0; mem_ok_i = 1;
          end
        end
      endcase
    end
  end

  typedef struct {
    string tag; bit spec; bit fail; bit ok; bit mchk;
    logic [31:0] r12, r13, pc, lock_a, lockw, hli_a, hli;
    int wr; int syn; int req;
  } exp_t;
  exp_t q[$];

  // monitor
  always @(negedge clk) begin
    if (sync_o) syn_cnt++;
    if (done_o) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "spec", {31'd0, spec_o}, {31'd0, e.spec});
      chk(e.tag, "r13_we", {31'd0, r13_we_o}, {31'd0, e.ok | e.fail});
      chk(e.tag, "r12_we", {31'd0, r12_we_o}, {31'd0, e.fail});
      chk(e.tag, "pc_we", {31'd0, pc_we_o}, {31'd0, e.fail});
      if (e.fail) begin
        chk(e.tag, "r12", r12_o, e.r12);
        chk(e.tag, "r13", r13_o, e.r13);
        chk(e.tag, "pc", pc_o, e.pc);
      end
      if (e.ok) chk(e.tag, "r13 zero", r13_o, 32'd0);
      if (e.mchk) begin
        chk(e.tag, "lockword", mrd(e.lock_a), e.lockw);
        chk(e.tag, "indicator", mrd(e.hli_a), e.hli);
      end
      chk(e.tag, "writes", wr_cnt, e.wr);
      chk(e.tag, "syncs", syn_cnt, e.syn);
      if (e.req >= 0) chk(e.tag, "requests", req_cnt, e.req);
      n_done++;
    end
  end

  // driver: computes the expected outcome from memory, then runs the operation
  task automatic run(input string tag, input int op, input bit fst, input bit am, input bit stl,
                     input logic [31:0] o1, input logic [31:0] o2, input logic [31:0] lp,
                     input logic [31:0] nia);
    exp_t e;
    logic [31:0] w1, h, lit, v, la, lk0, lk1, hn;
    logic [4:0] off;
    bit pass;
    int prev;
    e.tag = tag; e.spec = 0; e.fail = 0; e.ok = 0; e.mchk = 0; e.wr = 0; e.syn = 0; e.req = -1;
    e.r12 = {1'b0, nia[30:0]}; e.r13 = 0; e.pc = 0; e.lock_a = 0; e.lockw = 0; e.hli_a = 0; e.hli = 0;
    w1 = mrd(msk(o1, am)); h = mrd(msk(o2, am));
    lit = mrd(msk(msk(o2, am) + 4, am)); v = mrd(msk(msk(o2, am) - 4, am));
    la = (op == 0 || op == 2) ? msk(lp, am) : msk(msk(w1, am) + 32'h80, am);
    lk0 = mrd(la); lk1 = mrd(la + 4);
    off = (op == 0) ? 5'd8 : (op == 1) ? 5'd16 : (op == 2) ? 5'd4 : 5'd12;
    hn = msk(msk(lit, am) - {27'd0, off}, am);
    if (fst) e.req = 0;
    else if (o1[1:0] != 0 || o2[1:0] != 0) begin e.spec = 1; e.req = 0; end
    else if (la[2:0] != 0) begin e.spec = 1; e.req = (op == 1) ? 4 : 3; end
    else begin
      e.mchk = 1; e.lock_a = la; e.hli_a = msk(o2, am); e.lockw = lk0; e.hli = h;
      case (op)
        0: pass = h[0] && !h[1] && lk0 == 0;
        1: pass = lk0 == 0;
        2: pass = lk0 == w1 && h[1] && lk1 == 0;
        default: pass = h[0] && !h[1] && lk1 == 0;
      endcase
      if (op < 2) e.syn = 1;
      if (pass && stl) begin e.wr = 1; e.lockw = 32'hDEAD_0001; pass = 0; end
      if (pass) begin
        e.ok = 1; e.wr = 2;
        if (op < 2) e.syn = 2;
        case (op)
          0: begin e.lockw = w1; e.hli = h | 32'h2; end
          1: begin e.lockw = v;  e.hli = h | 32'h1; end
          2: begin e.lockw = 0;  e.hli = h & ~32'h2; end
          default: begin e.lockw = 0; e.hli = h & ~32'h1; end
        endcase
      end else begin
        e.fail = 1; e.r13 = mrd(hn); e.pc = msk(e.r13, am);
      end
    end
    q.push_back(e);
    @(negedge clk);
    wr_cnt = 0; req_cnt = 0; syn_cnt = 0; steal = stl;
    op_i = op[1:0]; fast_i = fst; amode_i = am; op1_addr_i = o1; op2_addr_i = o2;
    lock_ptr_i = lp; next_ia_i = nia; prev = n_done; start_i = 1;
    @(negedge clk); start_i = 0;
    while (n_done == prev) @(negedge clk);
    steal = 0;
  endtask

  // memory image: op1 word at 0x100, indicator at 0x200, value at 0x1FC, table base word at 0x204
  task automatic prep(input logic [31:0] w1, input logic [31:0] h, input logic [31:0] g0,
                      input logic [31:0] g1, input logic [31:0] l0, input logic [31:0] l1);
    mem[32'h100] = w1; mem[32'h200] = h; mem[32'h1FC] = 32'h0000_0077; mem[32'h204] = 32'h0000_4000;
    mem[32'h3FFC] = 32'h8000_1004; mem[32'h3FF8] = 32'h8000_1008;
    mem[32'h3FF4] = 32'h8000_100C; mem[32'h3FF0] = 32'hFF00_1010;
    mem[32'h3000] = g0; mem[32'h3004] = g1; mem[32'h5080] = l0; mem[32'h5084] = l1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R12", "reset done", {31'd0, done_o}, 0);
    chk("R12", "reset req", {31'd0, mem_req_o}, 0);
    chk("R9", "reset sync", {31'd0, sync_o}, 0);

    prep(32'h0000_0ABC, 32'h1, 0, 0, 0, 0);
    run("R3", 0, 0, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h8000_2004);
    prep(32'h0000_0ABC, 32'h1, 32'h55, 0, 0, 0);
    run("R1", 0, 0, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h8000_2004);
    prep(32'h0000_0ABC, 32'h0, 0, 0, 0, 0);
    run("R3", 0, 0, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h0000_2008);
    prep(32'hAB00_5000, 32'h0, 0, 0, 0, 0);
    run("R7", 1, 0, 0, 0, 32'h100, 32'h7F00_0200, 32'h3000, 32'h0000_200C);
    prep(32'h0000_5000, 32'h0, 0, 0, 32'h9, 0);
    run("R2", 1, 0, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h0000_2010);
    prep(32'h0000_5000, 32'h0, 0, 0, 32'h9, 0);
    run("R6", 1, 0, 0, 0, 32'h100, 32'h200, 32'h3000, 32'h0000_2010);
    prep(32'h0000_0ABC, 32'h3, 32'hABC, 0, 0, 0);
    run("R4", 2, 0, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h0000_2014);
    prep(32'h0000_0ABC, 32'h3, 32'hABD, 0, 0, 0);
    run("R5", 2, 0, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h0000_2018);
    prep(32'h0000_0ABC, 32'h3, 32'hABC, 32'h1, 0, 0);
    run("R4", 2, 0, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h0000_201C);
    prep(32'h0000_5000, 32'h1, 0, 0, 32'h77, 0);
    run("R4", 3, 0, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h0000_2020);
    prep(32'h0000_5000, 32'h3, 0, 0, 32'h77, 0);
    run("R5", 3, 0, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h0000_2024);
    prep(32'h0000_0ABC, 32'h1, 0, 0, 0, 0);
    run("R8", 0, 0, 1, 0, 32'h100, 32'h202, 32'h3000, 32'h0000_2028);
    prep(32'h0000_0ABC, 32'h1, 0, 0, 0, 0);
    run("R8", 0, 0, 1, 0, 32'h100, 32'h200, 32'h3004, 32'h0000_202C);
    prep(32'h0000_0ABC, 32'h1, 0, 0, 0, 0);
    run("R11", 0, 1, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h0000_2030);
    prep(32'h0000_0ABC, 32'h3, 32'hABC, 0, 0, 0);
    run("R11", 2, 1, 1, 0, 32'h100, 32'h200, 32'h3000, 32'h0000_2034);
    prep(32'h0000_0ABC, 32'h1, 0, 0, 0, 0);
    run("R10", 0, 0, 1, 1, 32'h100, 32'h200, 32'h3000, 32'h8000_2038);
    prep(32'h0000_5000, 32'h0, 0, 0, 0, 0);
    run("R10", 1, 0, 1, 1, 32'h100, 32'h200, 32'h3000, 32'h0000_203C);

    repeat (4) @(negedge clk);
    chk("R12", "queue drained", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog: actual %0d done expected more", n_done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule